// File: doc/BRIEF.md
# Flash Sector Write-Protection Guard

This block sits between a serial-flash command decoder and the storage array. It decides whether a program or erase command may touch the array. It keeps its own copy of the flash status byte. From that byte it derives a protection level and an end selector. The level fixes how many 64 KB sectors are locked, and the number grows by powers of two. The end selector says whether the locked region starts at the highest sector or at sector 0.

For each command, the guard extracts the target sector from the byte address. It then returns a registered allow/deny verdict one cycle later. A program or sector erase is refused when its sector lies inside the locked region. A whole-array erase is refused as soon as any sector is locked. A new status byte is captured on a write strobe. It governs only commands accepted after that capture edge.

Top module: `wp_guard`

## Requirements
- R1: The protection level is a 4-bit value built as {status[6], status[4], status[3], status[2]}. Status bit 5 selects the end (0 = top, 1 = bottom). Status bits 7, 1 and 0 have no effect on any verdict.
- R2: The locked sector count N is 0 for level 0. For any other level L it is the smaller of 2^(L-1) and the sector total (512 by default).
- R3: With bit 5 clear, the locked sectors are 512-N through 511.
- R4: With bit 5 set, the locked sectors are 0 through N-1.
- R5: The target sector is address bits [24:16]. The low 16 address bits do not change the verdict.
- R6: A program command (op code 0) is allowed exactly when its target sector is not locked.
- R7: A sector erase (op code 1) is allowed exactly when its target sector is not locked.
- R8: A whole-array erase (op code 2) is allowed exactly when N is 0.
- R9: Op code 3 is reserved and is always denied.
- R10: Every command accepted with cmd_valid high yields resp_valid high on the next cycle only. resp_allow is low whenever resp_valid is low.
- R11: A status byte written with stat_we applies to commands accepted on later edges. A command accepted on the same edge as the write is judged with the previous status.
- R12: After reset the stored status is 0, which means nothing is locked, and resp_valid and resp_allow are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stat_we | input | 1 | Capture strobe for the status byte |
| stat_byte | input | 8 | New flash status byte |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 2 | Command kind: 0 program, 1 sector erase, 2 whole-array erase, 3 reserved |
| cmd_addr | input | 25 | Byte address of the command target |
| resp_valid | output | 1 | Verdict valid, one cycle after the command |
| resp_allow | output | 1 | 1 = command may proceed, 0 = refused |

## Verification
The bench builds the guard with its default of 9 sector-index bits, which gives 512 sectors. Levels 11 through 15 then ask for more sectors than exist. This brings the clamp of the locked count to the whole array within reach. A full sweep of all sixteen levels at both ends probes the sectors on each side of every boundary. At full lock, the top and bottom regions coincide, so the end selector must stop mattering there.

// File: rtl/wp_pkg.sv
package wp_pkg;

  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_SERASE = 2'd1,
    OP_BULK   = 2'd2,
    OP_RSVD   = 2'd3
  } wp_op_e;

  // positions of the protection fields inside the status byte
  localparam int LVL_LO_POS  = 2;
  localparam int LVL_HI_POS  = 6;
  localparam int END_SEL_POS = 5;

  typedef struct packed {
    logic [3:0] level;
    logic       from_bottom;
  } wp_field_t;

endpackage

// File: rtl/wp_field_unpack.sv
module wp_field_unpack
  import wp_pkg::*;
(
  input  logic [7:0] stat,
  output wp_field_t  fld
);

  always_comb begin
    fld.level       = {stat[LVL_HI_POS], stat[LVL_LO_POS+2:LVL_LO_POS]};
    fld.from_bottom = stat[END_SEL_POS];
  end

endmodule

// File: rtl/wp_span.sv
module wp_span
  import wp_pkg::*;
#(
  parameter int SECT_BITS = 9
) (
  input  wp_field_t            fld,
  output logic [SECT_BITS:0]   cnt,
  output logic [SECT_BITS:0]   lo,
  output logic [SECT_BITS:0]   hi
);

  localparam int CW = SECT_BITS + 1;
  localparam logic [CW-1:0] NSECT = CW'(1) << SECT_BITS;

  // locked count: 0, else 2^(level-1) clamped to the array size
  function automatic logic [CW-1:0] lock_count(input logic [3:0] level);
    logic [3:0] sh;
    if (level == 4'd0) return '0;
    sh = level - 4'd1;
    if (int'(sh) >= SECT_BITS) return NSECT;
    return CW'(1) << sh;
  endfunction

  always_comb begin
    cnt = lock_count(fld.level);
    if (fld.from_bottom) begin
      lo = '0;
      hi = cnt;
    end else begin
      lo = NSECT - cnt;
      hi = NSECT;
    end
  end

endmodule

// File: rtl/wp_verdict.sv
module wp_verdict
  import wp_pkg::*;
#(
  parameter int SECT_BITS = 9
) (
  input  wp_op_e                 op,
  input  logic [SECT_BITS-1:0]   sector,
  input  logic [SECT_BITS:0]     cnt,
  input  logic [SECT_BITS:0]     lo,
  input  logic [SECT_BITS:0]     hi,
  output logic                   hit,
  output logic                   any_lock,
  output logic                   allow
);

  logic [SECT_BITS:0] sec_ext;

  always_comb begin
    sec_ext  = {1'b0, sector};
    hit      = (sec_ext >= lo) && (sec_ext < hi);
    any_lock = (cnt != '0);
    unique case (op)
      OP_PROG, OP_SERASE: allow = !hit;
      OP_BULK:            allow = !any_lock;
      default:            allow = 1'b0;
    endcase
  end

endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_pkg::*;
#(
  parameter int SECT_BITS  = 9,
  parameter int SECT_SHIFT = 16,
  parameter int ADDR_W     = SECT_BITS + SECT_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_we,
  input  logic [7:0]        stat_byte,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              resp_valid,
  output logic              resp_allow
);

  wp_field_t            fld_new;
  wp_field_t            fld_q;
  logic [SECT_BITS:0]   lock_cnt;
  logic [SECT_BITS:0]   lock_lo;
  logic [SECT_BITS:0]   lock_hi;
  logic [SECT_BITS-1:0] tgt_sector;
  logic                 tgt_hit;
  logic                 any_lock;
  logic                 verdict;

  logic unused_bits;
  assign unused_bits = ^{stat_byte[7], stat_byte[1:0], cmd_addr[SECT_SHIFT-1:0]};

  wp_field_unpack u_unpack (
    .stat (stat_byte),
    .fld  (fld_new)
  );

  // status fields held until the next capture strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fld_q <= '0;
    else if (stat_we) fld_q <= fld_new;
  end

  wp_span #(.SECT_BITS(SECT_BITS)) u_span (
    .fld (fld_q),
    .cnt (lock_cnt),
    .lo  (lock_lo),
    .hi  (lock_hi)
  );

  assign tgt_sector = cmd_addr[ADDR_W-1:SECT_SHIFT];

  wp_verdict #(.SECT_BITS(SECT_BITS)) u_verdict (
    .op       (wp_op_e'(cmd_op)),
    .sector   (tgt_sector),
    .cnt      (lock_cnt),
    .lo       (lock_lo),
    .hi       (lock_hi),
    .hit      (tgt_hit),
    .any_lock (any_lock),
    .allow    (verdict)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_allow <= 1'b0;
    end else begin
      resp_valid <= cmd_valid;
      resp_allow <= cmd_valid && verdict;
    end
  end

endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
  parameter int SECT_BITS = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic [1:0]         cmd_op,
  input logic               tgt_hit,
  input logic               any_lock,
  input logic [SECT_BITS:0] lock_cnt,
  input logic               resp_valid,
  input logic               resp_allow
);

  AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> resp_valid); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> (!resp_valid && !resp_allow)); // R10

  AST_COUNT_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lock_cnt) <= 1); // R2

  AST_LOCKED_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op != 2'd2 && tgt_hit) |=> !resp_allow); // R6

  AST_BULK_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd2 && any_lock) |=> !resp_allow); // R8

  AST_RSVD_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd3) |=> !resp_allow); // R9

  AST_FREE_ALLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op != 2'd3 && !any_lock) |=> resp_allow); // R7

endmodule

bind wp_guard wp_guard_chk #(.SECT_BITS(SECT_BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .tgt_hit    (tgt_hit),
  .any_lock   (any_lock),
  .lock_cnt   (lock_cnt),
  .resp_valid (resp_valid),
  .resp_allow (resp_allow)
);

// File: tb/wp_guard_test.sv
`timescale 1ns/1ps
module wp_guard_test;

  localparam int NS = 512;
  localparam int NV = 22;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stat_we = 1'b0;
  logic [7:0]  stat_byte = '0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [24:0] cmd_addr = '0;
  logic        resp_valid;
  logic        resp_allow;

  int n_checks = 0;
  int n_errors = 0;

  always #2 clk = ~clk;

  wp_guard uut (
    .clk(clk), .rst_n(rst_n), .stat_we(stat_we), .stat_byte(stat_byte),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .resp_valid(resp_valid), .resp_allow(resp_allow)
  );

  // {status, op, address, expected allow}
  localparam logic [35:0] VECS [NV] = '{
    {8'h00, 2'd0, 25'h1FF0000, 1'b1},  // R12 nothing locked
    {8'h04, 2'd0, 25'h1FF0000, 1'b0},  // R3
    {8'h04, 2'd0, 25'h1FE0000, 1'b1},  // R3
    {8'h24, 2'd0, 25'h0000000, 1'b0},  // R4
    {8'h24, 2'd0, 25'h0010000, 1'b1},  // R4
    {8'h10, 2'd1, 25'h1F80000, 1'b0},  // R7
    {8'h10, 2'd1, 25'h1F70000, 1'b1},  // R7
    {8'h30, 2'd1, 25'h0070000, 1'b0},  // R7
    {8'h30, 2'd1, 25'h0080000, 1'b1},  // R7
    {8'h48, 2'd0, 25'h0000000, 1'b0},  // R2 full
    {8'h7C, 2'd0, 25'h1FF0000, 1'b0},  // R2 clamp
    {8'h44, 2'd0, 25'h0FF0000, 1'b1},  // R6
    {8'h44, 2'd0, 25'h1000000, 1'b0},  // R6
    {8'h04, 2'd2, 25'h0000000, 1'b0},  // R8
    {8'h20, 2'd2, 25'h0000000, 1'b1},  // R8
    {8'h00, 2'd3, 25'h0000000, 1'b0},  // R9
    {8'h24, 2'd3, 25'h1000000, 1'b0},  // R9
    {8'h28, 2'd0, 25'h001FFFF, 1'b0},  // R5
    {8'h28, 2'd0, 25'h0020000, 1'b1},  // R5
    {8'h28, 2'd0, 25'h002ABCD, 1'b1},  // R5
    {8'h83, 2'd0, 25'h1FF0000, 1'b1},  // R1 stray bits
    {8'h87, 2'd0, 25'h1FF0000, 1'b0}   // R1
  };

  function automatic logic [7:0] mk(input int lvl, input bit bot);
    logic [3:0] l = 4'(lvl);
    return {1'b0, l[3], bot, l[2:0], 2'b00};
  endfunction

  function automatic bit model(input int lvl, input bit bot, input int op, input int sec);
    int n;
    bit locked;
    n = (lvl == 0) ? 0 : ((lvl - 1 >= 9) ? NS : (1 << (lvl - 1)));
    locked = bot ? (sec < n) : (sec >= NS - n);
    if (op == 0 || op == 1) return !locked;
    if (op == 2) return n == 0;
    return 1'b0;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic put_status(input logic [7:0] b);
    stat_we = 1'b1;
    stat_byte = b;
    @(negedge clk);
    stat_we = 1'b0;
  endtask

  task automatic issue(input int op, input logic [24:0] a, output logic v, output logic al);
    cmd_valid = 1'b1;
    cmd_op = 2'(op);
    cmd_addr = a;
    @(negedge clk);
    v = resp_valid;
    al = resp_allow;
    cmd_valid = 1'b0;
  endtask

  initial begin
    #800000;
    n_errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic v, al;
    repeat (3) @(negedge clk);
    chk("R12 resp_valid in reset", resp_valid, 1'b0);
    chk("R12 resp_allow in reset", resp_allow, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    issue(0, 25'h1FF0000, v, al);
    chk("R12 top sector free after reset", al, 1'b1);
    issue(2, 25'h0, v, al);
    chk("R12 bulk free after reset", al, 1'b1);

    for (int i = 0; i < NV; i++) begin
      put_status(VECS[i][35:28]);
      issue(int'(VECS[i][27:26]), VECS[i][25:1], v, al);
      chk($sformatf("R10 valid vec %0d", i), v, 1'b1);
      chk($sformatf("R6 table vec %0d", i), al, VECS[i][0]);
    end

    // R10 quiet cycle after a response
    @(negedge clk);
    chk("R10 resp_valid drops", resp_valid, 1'b0);
    chk("R10 resp_allow low when idle", resp_allow, 1'b0);

    // R11 status write on the same edge as a command
    put_status(mk(0, 1'b0));
    stat_we = 1'b1;
    stat_byte = mk(1, 1'b0);
    issue(0, 25'h1FF0000, v, al);
    stat_we = 1'b0;
    chk("R11 same-edge uses old status", al, 1'b1);
    issue(0, 25'h1FF0000, v, al);
    chk("R11 next command uses new status", al, 1'b0);

    // sweep of every level at both ends
    for (int lvl = 0; lvl < 16; lvl++) begin
      for (int b = 0; b < 2; b++) begin
        int n;
        int cand [7];
        n = (lvl == 0) ? 0 : ((lvl - 1 >= 9) ? NS : (1 << (lvl - 1)));
        cand = '{0, 1, n - 1, n, NS - n - 1, NS - n, NS - 1};
        put_status(mk(lvl, b[0]));
        for (int c = 0; c < 7; c++) begin
          int s = cand[c];
          if (s < 0 || s >= NS) continue;
          for (int op = 0; op < 2; op++) begin
            issue(op, 25'(s) << 16, v, al);
            chk($sformatf("%s lvl %0d sec %0d op %0d", b ? "R4" : "R3", lvl, s, op),
                al, model(lvl, b[0], op, s));
          end
        end
        issue(2, 25'h0, v, al);
        chk($sformatf("R8 bulk lvl %0d end %0d", lvl, b), al, model(lvl, b[0], 2, 0));
        issue(3, 25'h0, v, al);
        chk($sformatf("R9 rsvd lvl %0d", lvl), al, 1'b0);
      end
    end

    // R12 reset clears stored status
    put_status(mk(10, 1'b0));
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    issue(0, 25'h0, v, al);
    chk("R12 status cleared by reset", al, 1'b1);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule